// File: doc/BRIEF.md
# Byte-Wide SPI Master

This block is a memory-mapped SPI master that moves one byte at a time. Software sets the clock polarity, clock phase and bit order in a control register and picks a serial clock rate in a baud register. A write to the data register then starts an 8-bit full-duplex exchange on `sck_o`, `mosi_o` and `miso_i`. When the exchange ends, a completion flag is set and the received byte can be read from the same data offset. The flags use a two-step clear: software reads status, then reads data.

The slave-select line is driven by software through a small output port with its own direction register. A sense input watches for another master pulling the select line low. When this happens while the block is an enabled master, the block records a mode fault, stops any exchange that is in progress and drops out of master mode. A write to the data register while a byte is still shifting is refused and flagged as a collision, so software can retry it. Completion and mode fault each have their own interrupt output.

Top module: `spi_byte_master`

## Requirements
- R1: The registers decode at these offsets: control 0x00, auxiliary 0x01, baud 0x04, status 0x05, data 0x09, port 0x0D, direction 0x10. The auxiliary, port and direction registers read back as written. The control register reads back with bit 5 forced to 0. The baud register keeps only bits 6:4 and 2:0. Any other offset reads 0. Read data appears on the cycle after the read strobe.
- R2: After reset every register and every status flag is 0, `sck_o` is low, `ss_n_o` is high and both interrupts are low.
- R3: A data write starts an exchange only when control bit 6 (enable) and bit 4 (master) are both set and no byte is in flight. The master shifts out the written byte and captures 8 bits from `miso_i`. After completion the captured byte reads back at offset 0x09. If enable and master are not both set, the write produces no clock edges.
- R4: Each half period of `sck_o` lasts (P+1)·2^S bus clocks, where P is baud bits 6:4 and S is baud bits 2:0.
- R5: Control bit 3 sets the idle level of `sck_o`. With control bit 2 at 0, data is sampled on the first (leading) edge of each bit and changes on the trailing edge. With bit 2 at 1, data changes on the leading edge and is sampled on the trailing edge. An exchange has exactly 16 clock edges and leaves `sck_o` at its idle level.
- R6: With control bit 0 set, bit 0 is shifted first in both directions. Otherwise bit 7 is shifted first.
- R7: Completion sets status bit 7. `irq_done_o` is high while status bit 7 and control bit 7 are both set.
- R8: Status bits 7 and 6 clear only when a status read that saw them set is followed by a data read. A data read with no such status read before it leaves them set.
- R9: A data write while a byte is shifting sets status bit 6. The written value is dropped and the exchange in progress finishes unchanged.
- R10: A mode fault occurs when the block is an enabled master with control bit 1 clear and `ss_n_i` goes low. The fault sets status bit 4, clears control bits 6 and 4, and aborts any exchange without setting bit 7. `irq_fault_o` is high while status bit 4 and control bit 7 are both set. With control bit 1 set, `ss_n_i` is ignored.
- R11: Status bit 4 clears only when a status read that saw it set is followed by a write to the control register.
- R12: `port_o` equals the port register and `port_oe_o` equals the direction register. `ss_n_o` follows port bit 3 when direction bit 3 is set, and is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 5 | Register offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid on the cycle after the read strobe |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Select-line sense for mode-fault detection |
| ss_n_o | output | 1 | Active-low slave select |
| port_o | output | 8 | Port register value |
| port_oe_o | output | 8 | Port direction (1 = output) |
| irq_done_o | output | 1 | Completion interrupt |
| irq_fault_o | output | 1 | Mode-fault interrupt |

## Verification
The assertions check the following on every cycle:
- a collided write always leaves the collision flag set;
- the completion flag holds until its two-step clear;
- a mode fault always leaves master mode with nothing shifting;
- no exchange starts unless master mode is enabled;
- the completion pulse lasts a single cycle and the clock returns to its idle level;
- the divider ticks only while an exchange runs.

Other properties can only be shown by the bench scenarios, which run against a slave model:
- the received and transmitted bytes under all four clock modes and both bit orders;
- the measured half period for each baud setting;
- the ordering cases of the two-step clears.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BYTE_W = 8;

  // register offsets (software decodes these)
  localparam logic [ADDR_W-1:0] OFS_CTL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_AUX  = 5'h01;
  localparam logic [ADDR_W-1:0] OFS_BAUD = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h05;
  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h09;
  localparam logic [ADDR_W-1:0] OFS_PORT = 5'h0D;
  localparam logic [ADDR_W-1:0] OFS_DDIR = 5'h10;

  // control bit positions
  localparam int unsigned C_IE   = 7;
  localparam int unsigned C_EN   = 6;
  localparam int unsigned C_MS   = 4;
  localparam int unsigned C_CPOL = 3;
  localparam int unsigned C_CPHA = 2;
  localparam int unsigned C_SSOE = 1;
  localparam int unsigned C_LSBF = 0;
  localparam logic [BYTE_W-1:0] CTL_MASK = 8'hDF;

  // status bit positions
  localparam int unsigned S_DONE = 7;
  localparam int unsigned S_WCOL = 6;
  localparam int unsigned S_MODF = 4;

  localparam int unsigned SS_BIT       = 3;
  localparam int unsigned BAUD_PRE_LSB = 4;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsbf;
  } spi_mode_t;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int CNT_W = PRE_W + (1 << EXP_W);

  logic [CNT_W-1:0] half_w;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  assign half_w = (CNT_W'(pre_i) + CNT_W'(1)) << exp_i;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == half_w - CNT_W'(1)) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // divider only produces edges for a running exchange
  assert_tick_when_run_R4: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(run_i));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_byte_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              tick_i,
  input  spi_mode_t         mode_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int EDGE_N = 2 * WORD_W;
  localparam int EC_W   = $clog2(EDGE_N);

  spi_mode_t         mode_q;
  logic              busy_q, done_q, sck_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  logic [EC_W-1:0]   ec_q;
  logic              lead_w, sample_w, shift_w;

  assign lead_w   = ~ec_q[0];
  assign sample_w = mode_q.cpha ? ~lead_w : lead_w;
  assign shift_w  = mode_q.cpha ? (lead_w && ec_q != '0) : ~lead_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      ec_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
        ec_q   <= '0;
        sck_q  <= mode_q.cpol;
      end else if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        mode_q <= mode_i;
        tx_q   <= tx_i;
        ec_q   <= '0;
        sck_q  <= mode_i.cpol;
      end else if (busy_q && tick_i) begin
        sck_q <= ~sck_q;
        if (sample_w)
          rx_q <= mode_q.lsbf ? {miso_i, rx_q[WORD_W-1:1]} : {rx_q[WORD_W-2:0], miso_i};
        if (shift_w)
          tx_q <= mode_q.lsbf ? (tx_q >> 1) : (tx_q << 1);
        if (ec_q == EC_W'(EDGE_N - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          ec_q   <= '0;
        end else begin
          ec_q <= ec_q + EC_W'(1);
        end
      end else if (!busy_q) begin
        sck_q <= mode_i.cpol;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sck_o  = sck_q;
  assign mosi_o = mode_q.lsbf ? tx_q[0] : tx_q[WORD_W-1];

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_sck_idle_end_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (sck_q == mode_q.cpol));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              ss_n_i,
  output logic              ss_n_o,
  output logic [BYTE_W-1:0] port_o,
  output logic [BYTE_W-1:0] port_oe_o,
  output logic              irq_done_o,
  output logic              irq_fault_o
);
  logic [BYTE_W-1:0] ctl_q, aux_q, port_q, ddir_q, rxbuf_q, rdata_q;
  logic [PRE_W-1:0]  pre_q;
  logic [EXP_W-1:0]  exp_q;
  logic f_done_q, f_wcol_q, f_modf_q;
  logic seen_done_q, seen_wcol_q, seen_modf_q;

  logic wr_ctl, wr_data, rd_stat, rd_data;
  logic en_master, fault_w, start_w;
  logic core_busy, core_done, tick_w;
  logic [BYTE_W-1:0] core_rx, stat_w, baud_rd_w;
  spi_mode_t mode_w;

  assign wr_ctl  = bus_wr_i && (bus_addr_i == OFS_CTL);
  assign wr_data = bus_wr_i && (bus_addr_i == OFS_DATA);
  assign rd_stat = bus_rd_i && (bus_addr_i == OFS_STAT);
  assign rd_data = bus_rd_i && (bus_addr_i == OFS_DATA);

  assign en_master = ctl_q[C_EN] & ctl_q[C_MS];
  assign fault_w   = en_master & ~ctl_q[C_SSOE] & ~ss_n_i;
  assign start_w   = wr_data & en_master & ~core_busy & ~fault_w;

  always_comb begin
    mode_w.cpol = ctl_q[C_CPOL];
    mode_w.cpha = ctl_q[C_CPHA];
    mode_w.lsbf = ctl_q[C_LSBF];
    stat_w = '0;
    stat_w[S_DONE] = f_done_q;
    stat_w[S_WCOL] = f_wcol_q;
    stat_w[S_MODF] = f_modf_q;
    baud_rd_w = '0;
    baud_rd_w[BAUD_PRE_LSB +: PRE_W] = pre_q;
    baud_rd_w[0 +: EXP_W] = exp_q;
  end

  spi_baud_gen #(.PRE_W(PRE_W), .EXP_W(EXP_W)) baud_i (
    .clk(clk), .rst(rst), .run_i(core_busy),
    .pre_i(pre_q), .exp_i(exp_q), .tick_o(tick_w)
  );

  spi_shift_core #(.WORD_W(BYTE_W)) core_i (
    .clk(clk), .rst(rst), .start_i(start_w), .abort_i(fault_w),
    .tick_i(tick_w), .mode_i(mode_w), .tx_i(bus_wdata_i), .miso_i(miso_i),
    .busy_o(core_busy), .done_o(core_done), .rx_o(core_rx),
    .sck_o(sck_o), .mosi_o(mosi_o)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      aux_q  <= '0;
      pre_q  <= '0;
      exp_q  <= '0;
      port_q <= '0;
      ddir_q <= '0;
    end else begin
      if (fault_w) begin
        ctl_q[C_EN] <= 1'b0;
        ctl_q[C_MS] <= 1'b0;
      end else if (wr_ctl) begin
        ctl_q <= bus_wdata_i & CTL_MASK;
      end
      if (bus_wr_i && bus_addr_i == OFS_AUX)  aux_q  <= bus_wdata_i;
      if (bus_wr_i && bus_addr_i == OFS_PORT) port_q <= bus_wdata_i;
      if (bus_wr_i && bus_addr_i == OFS_DDIR) ddir_q <= bus_wdata_i;
      if (bus_wr_i && bus_addr_i == OFS_BAUD) begin
        pre_q <= bus_wdata_i[BAUD_PRE_LSB +: PRE_W];
        exp_q <= bus_wdata_i[0 +: EXP_W];
      end
    end
  end

  // flags with two-step clears; a new event wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      f_done_q    <= 1'b0;
      f_wcol_q    <= 1'b0;
      f_modf_q    <= 1'b0;
      seen_done_q <= 1'b0;
      seen_wcol_q <= 1'b0;
      seen_modf_q <= 1'b0;
      rxbuf_q     <= '0;
    end else begin
      if (core_done) rxbuf_q <= core_rx;
      f_done_q <= core_done | (f_done_q & ~(rd_data & seen_done_q));
      f_wcol_q <= (wr_data & core_busy) | (f_wcol_q & ~(rd_data & seen_wcol_q));
      f_modf_q <= fault_w | (f_modf_q & ~(wr_ctl & seen_modf_q));
      if (rd_stat) begin
        seen_done_q <= f_done_q;
        seen_wcol_q <= f_wcol_q;
        seen_modf_q <= f_modf_q;
      end else begin
        if (rd_data) begin
          seen_done_q <= 1'b0;
          seen_wcol_q <= 1'b0;
        end
        if (wr_ctl && !fault_w) seen_modf_q <= 1'b0;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd_i) begin
      case (bus_addr_i)
        OFS_CTL:  rdata_q <= ctl_q;
        OFS_AUX:  rdata_q <= aux_q;
        OFS_BAUD: rdata_q <= baud_rd_w;
        OFS_STAT: rdata_q <= stat_w;
        OFS_DATA: rdata_q <= rxbuf_q;
        OFS_PORT: rdata_q <= port_q;
        OFS_DDIR: rdata_q <= ddir_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
  assign port_o      = port_q;
  assign port_oe_o   = ddir_q;
  assign ss_n_o      = ddir_q[SS_BIT] ? port_q[SS_BIT] : 1'b1;
  assign irq_done_o  = ctl_q[C_IE] & f_done_q;
  assign irq_fault_o = ctl_q[C_IE] & f_modf_q;

  assert_no_start_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    !en_master |=> !$rose(core_busy));
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (f_done_q && !(rd_data && seen_done_q)) |=> f_done_q);
  assert_wcol_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_data && core_busy) |=> f_wcol_q);
  assert_modf_halt_R10: assert property (@(posedge clk) disable iff (rst)
    fault_w |=> (f_modf_q && !ctl_q[C_EN] && !ctl_q[C_MS] && !core_busy));
endmodule

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic       ss_n_in = 1'b1;
  logic       miso_r = 1'b0;
  wire  [7:0] rdata, port, port_oe;
  wire        sck, mosi, ss_n_out, irq_d, irq_f;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 1'b0;

  // slave model configuration (written only by tasks)
  logic       m_cpol = 0, m_cpha = 0, m_lsbf = 0;
  logic [7:0] sl_tx = '0;
  logic       prime_ev = 1'b0;
  // slave model state (written only by the slave process)
  logic       prime_seen = 1'b0;
  logic [7:0] sl_rx = '0;
  int lead = 0, trail = 0, sl_edges = 0, e0 = 0, e1 = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  spi_byte_master dut_i (
    .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso_r), .ss_n_i(ss_n_in), .ss_n_o(ss_n_out), .port_o(port),
    .port_oe_o(port_oe), .irq_done_o(irq_d), .irq_fault_o(irq_f)
  );

  function automatic int bpos(int i);
    return m_lsbf ? i : 7 - i;
  endfunction

  always @(sck or prime_ev) begin
    if (prime_ev != prime_seen) begin
      prime_seen = prime_ev;
      lead = 0; trail = 0; sl_edges = 0; sl_rx = '0;
      miso_r = sl_tx[bpos(0)];
    end else begin
      sl_edges = sl_edges + 1;
      if (sl_edges == 1) e0 = cyc;
      if (sl_edges == 2) e1 = cyc;
      if (sck !== m_cpol) begin
        if (!m_cpha) begin
          if (lead < 8) sl_rx[bpos(lead)] = mosi;
          lead = lead + 1;
        end else begin
          lead = lead + 1;
          if (lead <= 8) miso_r = sl_tx[bpos(lead - 1)];
        end
      end else begin
        if (!m_cpha) begin
          trail = trail + 1;
          if (trail < 8) miso_r = sl_tx[bpos(trail)];
        end else begin
          if (trail < 8) sl_rx[bpos(trail)] = mosi;
          trail = trail + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic prime(input logic cp, input logic ch, input logic lf, input logic [7:0] tx);
    m_cpol = cp; m_cpha = ch; m_lsbf = lf; sl_tx = tx;
    prime_ev = ~prime_ev;
    @(negedge clk);
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 5000; i++) begin
      if (irq_d) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] ctl_val(logic ie, logic cp, logic ch, logic lf);
    return {ie, 1'b1, 1'b0, 1'b1, cp, ch, 1'b0, lf};
  endfunction

  task automatic do_xfer(input logic ie, input logic cp, input logic ch, input logic lf,
                         input int pre, input int ex, input logic [7:0] mtx,
                         input logic [7:0] stx);
    logic [7:0] s, d;
    bus_write(5'h00, ctl_val(ie, cp, ch, lf));
    bus_write(5'h04, {1'b0, 3'(pre), 1'b0, 3'(ex)});
    repeat (2) @(negedge clk);
    prime(cp, ch, lf, stx);
    bus_write(5'h09, mtx);
    s = '0;
    for (int i = 0; i < 2000; i++) begin
      bus_read(5'h05, s);
      if (s[7]) break;
    end
    chk("R7 done flag", 32'(s[7]), 32'd1);
    chk("R7 irq follows enable", 32'(irq_d), 32'(ie));
    bus_read(5'h09, d);
    if (lf) chk("R6 lsb-first receive", 32'(d), 32'(stx));
    else    chk("R3 msb-first receive", 32'(d), 32'(stx));
    chk("R5 slave captured byte", 32'(sl_rx), 32'(mtx));
    chk("R5 edge count", 32'(sl_edges), 32'd16);
    chk("R5 idle level", 32'(sck), 32'(cp));
    chk("R4 half period", 32'(e1 - e0), 32'((pre + 1) << ex));
    bus_read(5'h05, s);
    chk("R8 flags cleared", 32'(s), 32'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk = nchk + 1; nfail = nfail + 1;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int seed;
    seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    chk("R2 sck", 32'(sck), 32'd0);
    chk("R2 ss_n_o", 32'(ss_n_out), 32'd1);
    chk("R2 irqs", 32'({irq_d, irq_f}), 32'd0);
    foreach (d[i]) ;
    bus_read(5'h00, d); chk("R2 control", 32'(d), 32'h00);
    bus_read(5'h05, d); chk("R2 status", 32'(d), 32'h00);
    bus_read(5'h04, d); chk("R2 baud", 32'(d), 32'h00);
    bus_read(5'h10, d); chk("R2 direction", 32'(d), 32'h00);

    // R1 register map
    bus_write(5'h01, 8'hA5); bus_read(5'h01, d); chk("R1 aux", 32'(d), 32'hA5);
    bus_write(5'h04, 8'hFF); bus_read(5'h04, d); chk("R1 baud mask", 32'(d), 32'h77);
    bus_write(5'h00, 8'hFF); bus_read(5'h00, d); chk("R1 control mask", 32'(d), 32'hDF);
    bus_write(5'h00, 8'h00);
    bus_write(5'h02, 8'h5A); bus_read(5'h02, d); chk("R1 unmapped", 32'(d), 32'h00);

    // R12 port and select
    bus_write(5'h0D, 8'h08); bus_write(5'h10, 8'h0E);
    bus_read(5'h0D, d); chk("R1 port readback", 32'(d), 32'h08);
    chk("R12 port_o", 32'(port), 32'h08);
    chk("R12 port_oe_o", 32'(port_oe), 32'h0E);
    chk("R12 select deasserted", 32'(ss_n_out), 32'd1);
    bus_write(5'h0D, 8'h00);
    chk("R12 select asserted", 32'(ss_n_out), 32'd0);
    bus_write(5'h10, 8'h00);
    chk("R12 select released as input", 32'(ss_n_out), 32'd1);

    // R3 write without master enable produces nothing
    bus_write(5'h00, 8'h80);
    repeat (2) @(negedge clk);
    prime(1'b0, 1'b0, 1'b0, 8'h3C);
    bus_write(5'h09, 8'h96);
    repeat (60) @(negedge clk);
    chk("R3 no edges when disabled", 32'(sl_edges), 32'd0);
    bus_read(5'h05, d); chk("R3 no flags when disabled", 32'(d), 32'h00);

    // directed: all modes, both orders, fastest and a slower rate
    for (int m = 0; m < 8; m++) begin
      do_xfer(1'b1, m[2], m[1], m[0], 0, 0, 8'hB4 ^ 8'(m), 8'h2D + 8'(m * 17));
      do_xfer(1'b0, m[2], m[1], m[0], 2, 1, 8'h81, 8'h7E);
    end

    // R8 data read without status read keeps the flag
    bus_write(5'h00, ctl_val(1'b1, 1'b0, 1'b0, 1'b0));
    bus_write(5'h04, 8'h00);
    repeat (2) @(negedge clk);
    prime(1'b0, 1'b0, 1'b0, 8'hE1);
    bus_write(5'h09, 8'h1E);
    bus_read(5'h05, d); chk("R8 status during shift", 32'(d), 32'h00);
    wait_irq();
    bus_read(5'h09, d); chk("R8 early status read does not arm", 32'(d), 32'hE1);
    bus_read(5'h05, d); chk("R8 flag kept after lone data read", 32'(d), 32'h80);
    bus_read(5'h09, d);
    bus_read(5'h05, d); chk("R8 cleared after status then data", 32'(d), 32'h00);
    chk("R7 irq dropped", 32'(irq_d), 32'd0);

    // R9 write collision
    bus_write(5'h00, ctl_val(1'b1, 1'b1, 1'b0, 1'b0));
    bus_write(5'h04, 8'h11);
    repeat (2) @(negedge clk);
    prime(1'b1, 1'b0, 1'b0, 8'h5B);
    bus_write(5'h09, 8'hC3);
    bus_write(5'h09, 8'h00);
    wait_irq();
    bus_read(5'h05, d); chk("R9 collision and done", 32'(d), 32'hC0);
    chk("R9 shift unchanged", 32'(sl_rx), 32'hC3);
    chk("R9 edge count", 32'(sl_edges), 32'd16);
    bus_read(5'h09, d); chk("R9 received byte", 32'(d), 32'h5B);
    bus_read(5'h05, d); chk("R9 collision cleared", 32'(d), 32'h00);

    // R10 / R11 mode fault
    bus_write(5'h00, 8'hD8);
    bus_write(5'h04, 8'h33);
    repeat (2) @(negedge clk);
    prime(1'b1, 1'b0, 1'b0, 8'hAA);
    bus_write(5'h09, 8'h55);
    repeat (20) @(negedge clk);
    ss_n_in = 1'b0;
    repeat (2) @(negedge clk);
    ss_n_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 fault irq", 32'(irq_f), 32'd1);
    chk("R10 clock idle after abort", 32'(sck), 32'd1);
    bus_read(5'h00, d); chk("R10 enable and master cleared", 32'(d), 32'h88);
    prime(1'b1, 1'b0, 1'b0, 8'hAA);
    bus_write(5'h09, 8'h55);
    repeat (300) @(negedge clk);
    chk("R10 no exchange after fault", 32'(sl_edges), 32'd0);
    bus_write(5'h00, 8'hD8);
    bus_read(5'h05, d); chk("R11 fault kept without status read", 32'(d), 32'h10);
    bus_write(5'h00, 8'hD8);
    bus_read(5'h05, d); chk("R11 fault cleared", 32'(d), 32'h00);
    chk("R11 fault irq low", 32'(irq_f), 32'd0);
    bus_write(5'h00, 8'hD2);
    ss_n_in = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(5'h05, d); chk("R10 sense ignored with bit 1 set", 32'(d), 32'h00);
    ss_n_in = 1'b1;

    // constrained random exchanges
    for (int k = 0; k < 24; k++) begin
      logic [7:0] mt, st;
      logic [2:0] mb;
      mt = 8'($urandom); st = 8'($urandom); mb = 3'($urandom);
      do_xfer(1'($urandom), mb[2], mb[1], mb[0], int'($urandom % 4),
              int'($urandom % 3), mt, st);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule